// File: doc/BRIEF.md
# Row-Sum Diagonal Preconditioner Generator

The block computes a positive diagonal scaling vector for a square matrix that arrives as a stream, one row after another. Each row is a run of signed fixed-point entries framed by a first-beat marker and a last-beat marker. The block adds up the magnitudes of a row's entries and emits one scale value per row, equal to the reciprocal square root of that magnitude sum. Each scale value is tagged with the row index given on the row's first beat. A downstream engine uses the vector to form the balanced system M·A·M and to map the balanced solution back by an elementwise product with the same vector.

Because each row carries its own index, a caller can send only the rows whose entries have changed, in any order, and receive fresh scales for just those rows. The reciprocal square root is found by even-power normalisation, a seed picked from the leading-one position and the next mantissa bit, and a fixed number of Newton steps. Each step is one pipeline stage, so the latency is constant and a new row may start on the cycle after the previous row's last beat. A row whose magnitudes sum to zero yields a reserved all-ones scale and sets a sticky flag.

Top module: `rowscale_gen`

## Requirements
- R1: For a row with magnitude sum S > 0, out_scale_o is an unsigned fixed-point value with OUT_W-1 = 15 fraction bits (1.0 = 0x8000), within 2 LSB of 32768/sqrt(S). It is never above 0x8000.
- R2: S is the sum of the absolute values of all accepted beats from the first-beat marker through the last-beat marker, reading in_data_i as two's complement. The value -2^(DATA_W-1) contributes 2^(DATA_W-1). S is exact for rows of up to MAX_COLS = 8 beats, the largest being 8 × 128 = 1024.
- R3: Exactly one result is produced per row. out_row_o carries the in_row_i value sampled on the row's first beat, so any subset of rows, in any order, can be refreshed.
- R4: out_valid_o is high for one cycle, NEWTON_STEPS + 3 = 6 rising edges after the edge that accepts the row's last beat, counting that edge as the first.
- R5: Results leave in the order the rows arrived. Rows may follow each other with no idle cycle, including one-beat rows that carry both markers on the same beat.
- R6: A row with S = 0 yields out_scale_o = 0xFFFF, and zero_flag_o rises together with that result. The flag stays high until reset.
- R7: While rst_ni is low, out_valid_o, zero_flag_o and in_ready_o are 0. From the first rising edge after reset is released, in_ready_o is 1.
- R8: A cycle with in_valid_i low adds nothing to the row sum, whatever in_data_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can accept a beat |
| in_data_i | input | DATA_W | Signed matrix entry |
| in_first_i | input | 1 | Beat is the first of a row |
| in_last_i | input | 1 | Beat is the last of a row |
| in_row_i | input | ROW_W | Row index, sampled on the first beat |
| out_valid_o | output | 1 | Scale result valid (one cycle) |
| out_row_o | output | ROW_W | Row index of the result |
| out_scale_o | output | OUT_W | Diagonal scale, Q1.(OUT_W-1), 0xFFFF for a zero row |
| zero_flag_o | output | 1 | Sticky: a zero-sum row has been seen |

## Verification
Every result is due exactly six rising edges after the edge that takes in its row's last beat. The bench stores that edge's number with the row's exact sum and index, and compares the arrival edge of each result against it. It drives on falling edges and samples on falling edges, so each check sees the registered outputs settled after the edge that made them. Expected scales come from a real-valued reciprocal square root of the bench's own magnitude sum. The sticky flag is checked before the zero row, on the cycle that row's result appears, and again after a later non-zero row.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // Seed bands: {m in [2,4), next mantissa bit}; value in thousandths.
  function automatic int unsigned seed_permille(input logic [1:0] band);
    case (band)
      2'b00:   return 905;  // m in [1,1.5)
      2'b01:   return 760;  // m in [1.5,2)
      2'b10:   return 640;  // m in [2,3)
      default: return 536;  // m in [3,4)
    endcase
  endfunction

endpackage

// File: rtl/rsp_row_accum.sv
module rsp_row_accum #(
  parameter int DATA_W   = 8,
  parameter int MAX_COLS = 8,
  parameter int ROW_W    = 4,
  parameter int ACC_W    = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     beat_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic [ROW_W-1:0]         row_i,
  output logic                     done_o,
  output logic [ACC_W-1:0]         sum_o,
  output logic [ROW_W-1:0]         row_o
);
  localparam int CNT_W = $clog2(MAX_COLS + 1) + 1;

  logic [DATA_W:0]    ext, mag;
  logic [ACC_W-1:0]   acc_q, base, acc_n;
  logic [ROW_W-1:0]   rowc_q, row_cur;
  logic [CNT_W-1:0]   cnt_q;

  always_comb begin
    ext     = {data_i[DATA_W-1], data_i};
    mag     = data_i[DATA_W-1] ? (~ext + 1'b1) : ext;
    base    = first_i ? '0 : acc_q;
    acc_n   = base + ACC_W'(mag);
    row_cur = first_i ? row_i : rowc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rowc_q <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      sum_o  <= '0;
      row_o  <= '0;
    end else begin
      done_o <= beat_i && last_i;
      if (beat_i) begin
        acc_q  <= acc_n;
        rowc_q <= row_cur;
        cnt_q  <= first_i ? CNT_W'(1) : cnt_q + 1'b1;
        if (last_i) begin
          sum_o <= acc_n;
          row_o <= row_cur;
        end
      end
    end
  end

  // R2: rows stay within the sized length, and the sum never wraps
  assert_row_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !first_i) |-> (cnt_q < CNT_W'(MAX_COLS)));
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (acc_n >= base));

endmodule

// File: rtl/rsp_seed.sv
module rsp_seed
  import rsp_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int FRAC  = 20,
  parameter int ROW_W = 4,
  parameter int E_W   = 4,
  parameter int R_W   = FRAC + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             v_o,
  output logic [R_W-1:0]   m_o,
  output logic [R_W-1:0]   r_o,
  output logic [ROW_W-1:0] row_o,
  output logic [E_W-1:0]   e_o,
  output logic             zero_o
);
  logic [E_W-1:0]        lead, e;
  logic [ACC_W+FRAC-1:0] mfull;
  logic [R_W-1:0]        m, seed;
  logic [1:0]            band;

  always_comb begin
    lead = '0;
    for (int i = 0; i < ACC_W; i++) if (sum_i[i]) lead = E_W'(i);
    e     = lead >> 1;
    // S = m * 4^e with m in [1,4), m held with FRAC fraction bits
    mfull = {sum_i, {FRAC{1'b0}}} >> {e, 1'b0};
    m     = mfull[R_W-1:0];
    band  = {m[FRAC+1], m[FRAC+1] ? m[FRAC] : m[FRAC-1]};
    seed  = R_W'((64'(seed_permille(band)) << FRAC) / 64'd1000);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      m_o    <= '0;
      r_o    <= '0;
      row_o  <= '0;
      e_o    <= '0;
      zero_o <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        m_o    <= m;
        r_o    <= seed;
        row_o  <= row_i;
        e_o    <= e;
        zero_o <= (sum_i == '0);
      end
    end
  end

endmodule

// File: rtl/rsp_newton_step.sv
module rsp_newton_step #(
  parameter int FRAC   = 20,
  parameter int R_W    = FRAC + 2,
  parameter int META_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              v_i,
  input  logic [R_W-1:0]    m_i,
  input  logic [R_W-1:0]    r_i,
  input  logic [META_W-1:0] meta_i,
  output logic              v_o,
  output logic [R_W-1:0]    m_o,
  output logic [R_W-1:0]    r_o,
  output logic [META_W-1:0] meta_o
);
  localparam int P_W = 2 * R_W;
  localparam logic [R_W-1:0] THREE   = R_W'(64'd3 << FRAC);
  localparam logic [R_W-1:0] ONE     = R_W'(64'd1 << FRAC);
  localparam logic [R_W-1:0] QUARTER = R_W'(64'd1 << (FRAC - 2));

  logic [P_W-1:0] p_rr, p_mt, p_rv;
  logic [R_W-1:0] t, u, v, rn;

  // r' = r * (3 - m*r^2) / 2
  always_comb begin
    p_rr = {{R_W{1'b0}}, r_i} * {{R_W{1'b0}}, r_i};
    t    = p_rr[FRAC +: R_W];
    p_mt = {{R_W{1'b0}}, m_i} * {{R_W{1'b0}}, t};
    u    = p_mt[FRAC +: R_W];
    v    = THREE - u;
    p_rv = {{R_W{1'b0}}, r_i} * {{R_W{1'b0}}, v};
    rn   = p_rv[FRAC+1 +: R_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      m_o    <= '0;
      r_o    <= '0;
      meta_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        m_o    <= m_i;
        r_o    <= rn;
        meta_o <= meta_i;
      end
    end
  end

  // R1: every refined estimate for a non-zero row lies in (0.25, 1.0]
  assert_newton_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_o && !meta_o[0]) |-> (r_o <= ONE && r_o > QUARTER));

endmodule

// File: rtl/rowscale_gen.sv
module rowscale_gen #(
  parameter int DATA_W       = 8,
  parameter int MAX_COLS     = 8,
  parameter int ROW_W        = 4,
  parameter int OUT_W        = 16,
  parameter int FRAC         = 20,
  parameter int NEWTON_STEPS = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic                     in_first_i,
  input  logic                     in_last_i,
  input  logic [ROW_W-1:0]         in_row_i,
  output logic                     out_valid_o,
  output logic [ROW_W-1:0]         out_row_o,
  output logic [OUT_W-1:0]         out_scale_o,
  output logic                     zero_flag_o
);
  localparam int ACC_W  = DATA_W + $clog2(MAX_COLS) + 1;
  localparam int E_W    = $clog2(ACC_W);
  localparam int R_W    = FRAC + 2;
  localparam int META_W = ROW_W + E_W + 1;
  localparam int SH_BASE = FRAC - (OUT_W - 1);

  logic             beat, done_s0;
  logic [ACC_W-1:0] sum_s0;
  logic [ROW_W-1:0] row_s0, row_s1;
  logic [E_W-1:0]   e_s1;
  logic             zero_s1;

  logic                       st_v    [NEWTON_STEPS+1];
  logic [R_W-1:0]             st_m    [NEWTON_STEPS+1];
  logic [R_W-1:0]             st_r    [NEWTON_STEPS+1];
  logic [META_W-1:0]          st_meta [NEWTON_STEPS+1];

  assign beat = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_ready_o <= 1'b0;
    else         in_ready_o <= 1'b1;
  end

  rsp_row_accum #(.DATA_W(DATA_W), .MAX_COLS(MAX_COLS), .ROW_W(ROW_W), .ACC_W(ACC_W)) u_accum (
    .clk_i, .rst_ni, .beat_i(beat), .data_i(in_data_i), .first_i(in_first_i),
    .last_i(in_last_i), .row_i(in_row_i), .done_o(done_s0), .sum_o(sum_s0), .row_o(row_s0)
  );

  rsp_seed #(.ACC_W(ACC_W), .FRAC(FRAC), .ROW_W(ROW_W), .E_W(E_W), .R_W(R_W)) u_seed (
    .clk_i, .rst_ni, .v_i(done_s0), .sum_i(sum_s0), .row_i(row_s0),
    .v_o(st_v[0]), .m_o(st_m[0]), .r_o(st_r[0]), .row_o(row_s1), .e_o(e_s1), .zero_o(zero_s1)
  );

  assign st_meta[0] = {row_s1, e_s1, zero_s1};

  for (genvar g = 0; g < NEWTON_STEPS; g++) begin : g_newton
    rsp_newton_step #(.FRAC(FRAC), .R_W(R_W), .META_W(META_W)) u_step (
      .clk_i, .rst_ni, .v_i(st_v[g]), .m_i(st_m[g]), .r_i(st_r[g]), .meta_i(st_meta[g]),
      .v_o(st_v[g+1]), .m_o(st_m[g+1]), .r_o(st_r[g+1]), .meta_o(st_meta[g+1])
    );
  end

  logic [ROW_W-1:0] fin_row;
  logic [E_W-1:0]   fin_e;
  logic             fin_zero;
  logic [R_W-1:0]   scaled;

  always_comb begin
    {fin_row, fin_e, fin_zero} = st_meta[NEWTON_STEPS];
    // y = r * 2^-e, re-expressed with OUT_W-1 fraction bits
    scaled = st_r[NEWTON_STEPS] >> (R_W'(SH_BASE) + R_W'(fin_e));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_row_o   <= '0;
      out_scale_o <= '0;
      zero_flag_o <= 1'b0;
    end else begin
      out_valid_o <= st_v[NEWTON_STEPS];
      if (st_v[NEWTON_STEPS]) begin
        out_row_o   <= fin_row;
        out_scale_o <= fin_zero ? '1 : scaled[OUT_W-1:0];
        if (fin_zero) zero_flag_o <= 1'b1;
      end
    end
  end

  // R4: a result leaves a fixed number of edges after its row sum closed
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(done_s0, NEWTON_STEPS + 2));
  // R6: flag is sticky and accompanies the reserved code
  assert_zero_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_flag_o |=> zero_flag_o);
  assert_zero_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_scale_o == '1) |-> zero_flag_o);
  // R1: non-reserved results never exceed 1.0
  assert_scale_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_scale_o != '1) |-> (out_scale_o <= OUT_W'(1 << (OUT_W - 1))));

endmodule

// File: tb/rowscale_gen_tb.sv
module rowscale_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;
  localparam int DEPTH      = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic signed [7:0] in_data = '0;
  logic [3:0] in_row = '0;
  logic in_ready, out_valid, zero_flag;
  logic [3:0] out_row;
  logic [15:0] out_scale;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int exp_sum [DEPTH];
  int exp_row [DEPTH];
  int exp_cyc [DEPTH];
  int wr = 0, rd = 0;
  int row_buf [8];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rowscale_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_first_i(in_first), .in_last_i(in_last), .in_row_i(in_row),
    .out_valid_o(out_valid), .out_row_o(out_row), .out_scale_o(out_scale), .zero_flag_o(zero_flag)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: every result checked for order, index, latency and value
  always @(negedge clk) begin
    if (rst_ni && out_valid) begin
      if (rd == wr) begin
        check(1'b0, "R3", "unexpected result", int'(out_row), -1);
      end else begin
        check(cyc == exp_cyc[rd] + LAT, "R4", "latency edge", cyc, exp_cyc[rd] + LAT);
        check(int'(out_row) == exp_row[rd], "R3/R5", "row tag", int'(out_row), exp_row[rd]);
        if (exp_sum[rd] == 0) begin
          check(out_scale == 16'hFFFF, "R6", "zero-row code", int'(out_scale), 16'hFFFF);
          check(zero_flag == 1'b1, "R6", "flag with zero row", int'(zero_flag), 1);
        end else begin
          real e, d;
          e = 32768.0 / $sqrt(real'(exp_sum[rd]));
          d = real'(out_scale) - e;
          check(d <= 2.0 && d >= -2.0, "R1/R2", "scale", int'(out_scale), int'(e + 0.5));
        end
        rd++;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  // Sends row_buf[0..n-1]; gap puts an invalid beat with junk data before each later beat (R8)
  task automatic send_row(input int row, input int n, input bit gap);
    int s = 0;
    for (int j = 0; j < n; j++) begin
      if (gap && j > 0) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'sh7f; in_first = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(row_buf[j]);
      in_first = (j == 0);
      in_last  = (j == n - 1);
      in_row   = 4'(row);
      s += (row_buf[j] < 0) ? -row_buf[j] : row_buf[j];
      if (j == n - 1) begin
        exp_sum[wr] = s; exp_row[wr] = row; exp_cyc[wr] = cyc; wr++;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && rd != wr; i++) @(negedge clk);
    check(rd == wr, "R3", "results outstanding", wr - rd, 0);
  endtask

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
    check(zero_flag == 1'b0, "R7", "flag in reset", int'(zero_flag), 0);
    check(in_ready == 1'b0, "R7", "ready in reset", int'(in_ready), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "ready after reset", int'(in_ready), 1);

    // R1/R5: every non-zero single-beat value, back to back
    for (int v = -128; v < 128; v++) begin
      if (v != 0) begin
        row_buf[0] = v;
        send_row(v & 15, 1, 1'b0);
      end
    end
    idle(1);
    drain();

    // R2: multi-beat rows of every length, several patterns, back to back
    for (int len = 1; len <= 8; len++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int j = 0; j < len; j++) begin
          case (pat)
            0: row_buf[j] = -128;
            1: row_buf[j] = (j % 2 == 0) ? (j + 1) * 13 : -(j + 1) * 11;
            2: row_buf[j] = 127 - 31 * j;
            default: row_buf[j] = (j == len - 1) ? 1 : 0;
          endcase
        end
        send_row((len * 4 + pat) & 15, len, 1'b0);
      end
    end
    idle(1);
    drain();

    // R8: invalid beats with junk data inside rows
    for (int len = 2; len <= 8; len += 3) begin
      for (int j = 0; j < len; j++) row_buf[j] = 5 * j - 9;
      send_row(len, len, 1'b1);
    end
    idle(2);
    drain();

    // R3: partial refresh of a few rows in arbitrary order
    row_buf[0] = 3;  row_buf[1] = -4;  send_row(13, 2, 1'b0);
    row_buf[0] = 64;                   send_row(2, 1, 1'b0);
    row_buf[0] = -1; row_buf[1] = -1; row_buf[2] = 2; send_row(7, 3, 1'b0);
    idle(1);
    drain();

    // R6: flag still clear, then a zero row sets it and it stays set
    check(zero_flag == 1'b0, "R6", "flag before zero row", int'(zero_flag), 0);
    row_buf[0] = 0; row_buf[1] = 0; row_buf[2] = 0;
    send_row(9, 3, 1'b0);
    row_buf[0] = 100; send_row(10, 1, 1'b0);
    idle(1);
    drain();
    idle(3);
    check(zero_flag == 1'b1, "R6", "flag sticky", int'(zero_flag), 1);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule